// File: doc/BRIEF.md
# Sparse Two-Tap FIR Filter

This block is a small fixed-weight FIR filter with exactly two taps. Each clock it may accept one single-bit unsigned sample, qualified by a sample strobe. It produces a registered signed sum: the near tap weights the newest sample by 1, and the far tap weights an older sample by 3.

A compile-time mode picks how far apart the taps sit. In single-rate mode the far tap reads the sample taken just before the current one. In zero-packed mode the far tap reads the sample four accepted samples back. This matches a coefficient set padded with three zeros, built from a short delay line instead of extra multipliers.

Because the input is one bit, each tap is a select between its weight and zero, not a multiply. The history advances only on accepted samples. Samples on clocks without the strobe are not part of the sequence.

Top module: `fir2_zp`

## Requirements
- R1: While reset is high, at the next clock edge the sum output becomes 0, the output valid flag becomes 0 and the delay history is emptied. After reset, samples older than reset count as 0.
- R2: On a clock edge where the strobe is high, the sum output becomes 1·x[n] + 3·x[n−D]. Here x[n] is the bit presented at that edge, x[n−D] is the bit accepted D strobed samples earlier, and D is the tap spacing.
- R3: The tap spacing D is 1 in single-rate mode (MODE_SINGLE) and 4 in zero-packed mode (MODE_PACKED, the default). That leaves three sample slots between the taps.
- R4: The sum output is registered. A sample presented before an edge is reflected in the sum after that edge, and not before it.
- R5: The output valid flag equals the sample strobe of the previous clock edge.
- R6: On an edge where the strobe is low, the sum output and the delay history keep their values, and the bit presented is ignored.
- R7: The sum output is 4 bits signed. Its largest value is 4 (binary 0100), reached when both taps see a 1, and it never wraps.
- R8: Each tap adds its weight when the bit it reads is 1 and adds 0 when it is 0. An accepted 0 as the newest bit therefore leaves a sum of 0 or 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample strobe; the bit is accepted when high |
| smp_bit | input | 1 | Unsigned one-bit input sample |
| acc_q | output | 4 | Registered signed two-tap sum |
| acc_valid | output | 1 | Strobe delayed by one clock |

## Verification
Every result of this block is due one clock after the edge that captured its sample. The far-tap contribution appears only after D more accepted samples, however many idle clocks sit between them. The bench drives inputs on the falling edge and compares both outputs half a period later against a behavioural model, which keeps a queue of accepted bits. Two instances run in lockstep, one per spacing mode, so the same stimulus shows both spacings. The stimulus covers reset, isolated pulses, all-ones runs, strobe gaps and mid-run reset.

// File: rtl/fir2_pkg.sv
package fir2_pkg;

    typedef enum logic [0:0] {
        MODE_SINGLE = 1'b0,
        MODE_PACKED = 1'b1
    } fir_mode_e;

    localparam int PACK_FACTOR = 4;

    function automatic int tap_spacing(input fir_mode_e mode);
        int sp;
        unique case (mode)
            MODE_SINGLE: sp = 1;
            MODE_PACKED: sp = PACK_FACTOR;
            default:     sp = 1;
        endcase
        return sp;
    endfunction

endpackage

// File: rtl/fir2_delay.sv
module fir2_delay #(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] line_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst)      line_q <= '0;
                else if (adv) line_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst)      line_q <= '0;
                else if (adv) line_q <= {line_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = line_q[DEPTH-1];
endmodule

// File: rtl/fir2_tap.sv
module fir2_tap #(
    parameter int                    CW   = 3,
    parameter int                    OW   = 4,
    parameter logic signed [CW-1:0]  COEF = 3'sd1
) (
    input  logic                 sel,
    output logic signed [OW-1:0] term
);
    localparam logic signed [OW-1:0] WEIGHT = OW'(COEF);

    always_comb begin
        term = sel ? WEIGHT : '0;
    end
endmodule

// File: rtl/fir2_zp.sv
module fir2_zp
    import fir2_pkg::*;
#(
    parameter fir_mode_e            MODE      = MODE_PACKED,
    parameter int                   COEF_W    = 3,
    parameter int                   OUT_W     = 4,
    parameter logic signed [2:0]    COEF_NEAR = 3'sd1,
    parameter logic signed [2:0]    COEF_FAR  = 3'sd3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    smp_valid,
    input  logic                    smp_bit,
    output logic signed [OUT_W-1:0] acc_q,
    output logic                    acc_valid
);
    localparam int SPACING = tap_spacing(MODE);
    localparam int FAR_VAL = int'(COEF_FAR);
    localparam int MAX_SUM = int'(COEF_NEAR) + int'(COEF_FAR);

    logic                    far_bit;
    logic signed [OUT_W-1:0] near_term;
    logic signed [OUT_W-1:0] far_term;
    logic signed [OUT_W-1:0] sum_d;

    fir2_delay #(.DEPTH(SPACING)) u_line (
        .clk  (clk),
        .rst  (rst),
        .adv  (smp_valid),
        .din  (smp_bit),
        .dout (far_bit)
    );

    fir2_tap #(.CW(COEF_W), .OW(OUT_W), .COEF(COEF_NEAR)) u_near (
        .sel  (smp_bit),
        .term (near_term)
    );

    fir2_tap #(.CW(COEF_W), .OW(OUT_W), .COEF(COEF_FAR)) u_far (
        .sel  (far_bit),
        .term (far_term)
    );

    always_comb begin
        sum_d = near_term + far_term;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            acc_valid <= 1'b0;
        end else begin
            acc_valid <= smp_valid;
            if (smp_valid) acc_q <= sum_d;
        end
    end
endmodule

// File: rtl/fir2_zp_chk.sv
module fir2_zp_chk #(
    parameter int OW   = 4,
    parameter int MAXV = 4,
    parameter int FAR  = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 smp_valid,
    input logic                 smp_bit,
    input logic signed [OW-1:0] acc_q,
    input logic                 acc_valid
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && !acc_valid));

    assert_valid_follow_R5: assert property (@(posedge clk) disable iff (rst)
        smp_valid |=> acc_valid);

    assert_valid_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !acc_valid);

    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> $stable(acc_q));

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (int'(acc_q) >= 0 && int'(acc_q) <= MAXV));

    assert_zero_near_R8: assert property (@(posedge clk) disable iff (rst)
        (smp_valid && !smp_bit) |=> (int'(acc_q) == 0 || int'(acc_q) == FAR));
endmodule

bind fir2_zp fir2_zp_chk #(.OW(OUT_W), .MAXV(MAX_SUM), .FAR(FAR_VAL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .smp_valid (smp_valid),
    .smp_bit   (smp_bit),
    .acc_q     (acc_q),
    .acc_valid (acc_valid)
);

// File: tb/fir2_zp_test.sv
module fir2_zp_test;
    import fir2_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic clk = 1'b0;
    logic rst, smp_valid, smp_bit;
    logic signed [3:0] acc_zp, acc_sr;
    logic vld_zp, vld_sr;

    int checks = 0, fails = 0, cyc = 0;
    int hist_zp[$], hist_sr[$];
    int exp_zp = 0, exp_sr = 0, exp_v = 0;
    bit have_exp = 0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    fir2_zp #(.MODE(MODE_PACKED)) uut (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_bit(smp_bit),
        .acc_q(acc_zp), .acc_valid(vld_zp)
    );

    fir2_zp #(.MODE(MODE_SINGLE)) uut_sr (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_bit(smp_bit),
        .acc_q(acc_sr), .acc_valid(vld_sr)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic int far_of(ref int h[$], input int d);
        if (h.size() >= d) return h[h.size()-d];
        return 0;
    endfunction

    // compare outputs of the last edge, then drive the next inputs and model them
    task automatic step(input bit r, input bit v, input bit b, input string tag);
        @(negedge clk);
        if (have_exp) begin
            check({cur_tag, " zero-packed sum R2"}, int'(acc_zp), exp_zp);
            check({cur_tag, " single-rate sum R3"}, int'(acc_sr), exp_sr);
            check({cur_tag, " valid R5"}, int'(vld_zp), exp_v);
            check({cur_tag, " valid R5"}, int'(vld_sr), exp_v);
        end
        rst = r; smp_valid = v; smp_bit = b;
        cur_tag = tag;
        have_exp = 1;
        if (r) begin
            hist_zp.delete(); hist_sr.delete();
            exp_zp = 0; exp_sr = 0; exp_v = 0;
        end else begin
            exp_v = int'(v);
            if (v) begin
                exp_zp = int'(b) * 1 + 3 * far_of(hist_zp, 4);
                exp_sr = int'(b) * 1 + 3 * far_of(hist_sr, 1);
                hist_zp.push_back(int'(b));
                hist_sr.push_back(int'(b));
            end
        end
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > WATCHDOG) begin
                fails++; checks++;
                $display("FAIL watchdog: actual %0d expected below %0d cycles", cyc, WATCHDOG);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        int lfsr = 16'hACE1;
        rst = 1'b1; smp_valid = 1'b0; smp_bit = 1'b0;
        // R1: reset state
        for (int i = 0; i < 3; i++) step(1, 1, 1, "R1");
        // R4 and R8: single pulse, then zeros to see the far tap
        step(0, 1, 1, "R4 R8");
        for (int i = 0; i < 6; i++) step(0, 1, 0, "R4 R8");
        // R7: run of ones reaches the maximum
        for (int i = 0; i < 8; i++) step(0, 1, 1, "R7");
        // R6: strobe gaps with toggling bits are ignored
        step(0, 1, 0, "R6");
        for (int i = 0; i < 5; i++) step(0, 0, i[0], "R6");
        step(0, 1, 0, "R6");
        for (int i = 0; i < 3; i++) step(0, 0, 1, "R6");
        for (int i = 0; i < 4; i++) step(0, 1, 0, "R6");
        // R2 / R3: pseudo-random bits with sparse strobe gaps
        for (int i = 0; i < 200; i++) begin
            lfsr = ((lfsr >> 1) ^ ((lfsr & 1) ? 16'hB400 : 0)) & 16'hFFFF;
            step(0, (lfsr % 5) != 0, lfsr[3], "R2");
        end
        // R1: reset mid-run clears history
        for (int i = 0; i < 3; i++) step(0, 1, 1, "R1");
        step(1, 1, 1, "R1");
        step(0, 1, 0, "R1");
        for (int i = 0; i < 5; i++) step(0, 1, 0, "R1");
        step(0, 0, 0, "R5");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule